// File: doc/BRIEF.md
# Exception and Interrupt Entry Unit

This unit decides, once per cycle, whether the core enters its privileged handler code and where. It accepts an exception request carrying a cause code and an error code, and four interrupt request lines. Interrupts are masked by the current priority level of the processor and are blocked completely while the core is already in privileged mode. When an entry is taken, the unit works out the handler address as the privileged base register plus an offset for the cause. It records the return address with the mode tag in bit 0 and forces the mode flag to privileged.

The outputs are registered. All of them change together on the clock edge that samples the request. A one-cycle taken strobe marks each entry. A cause code outside the defined set raises an error strobe instead, and no state changes.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `taken_o`, `cause_err_o`, `mode_o`, `pc_o`, `exc_addr_o` and `err_code_o` are all zero.
- R2: While `mode_i` is 1, no interrupt is taken. Exceptions are still taken.
- R3: Interrupt line k is eligible only when `ipl_i` < 4+k. The line indices are 0 device, 1 timer, 2 inter-processor and 3 machine check. Level 4 masks device, level 5 also masks timer, level 6 leaves only machine check, and level 7 masks all four.
- R4: Among eligible lines the highest index wins. The order is machine check, inter-processor, timer, device. The winner's cause is 1, 2, 3 or 4 in that order.
- R5: Cause codes 0 to 9 mean reset, machine check, inter-processor, clock, device, memory fault, unaligned, illegal opcode, arithmetic and FP disabled. Cause c in this range has offset c*0x80.
- R6: Cause 10 is a call trap and uses `exc_code_i` as its code c. If bit 7 of c is set the offset is 0x2000 + (c-0x80)*64; otherwise it is 0x1000 + c*64.
- R7: On an entry, `exc_addr_o` becomes `pc_i` with bit 0 ORed with `mode_i`.
- R8: On an entry, `pc_o` becomes `base_i` + offset and `mode_o` becomes 1. Without an entry, `pc_o`, `exc_addr_o`, `mode_o` and `err_code_o` hold their values.
- R9: An interrupt entry sets `err_code_o` to 0. An exception entry sets it to `exc_code_i`.
- R10: An exception request takes precedence over any interrupt in the same cycle.
- R11: An exception request with cause 11 to 15 pulses `cause_err_o` for one cycle. No entry is taken and no held output changes.
- R12: Every result appears on the clock edge after the inputs are sampled, so back-to-back requests produce back-to-back entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 4 | Interrupt lines: 0 device, 1 timer, 2 inter-processor, 3 machine check |
| ipl_i | input | 3 | Current interrupt priority level |
| exc_req_i | input | 1 | Exception request |
| exc_cause_i | input | 4 | Exception cause code |
| exc_code_i | input | 8 | Error code (call-trap number for cause 10) |
| mode_i | input | 1 | Current privileged-mode flag |
| pc_i | input | ADDR_W | Current PC |
| base_i | input | ADDR_W | Privileged code base address |
| taken_o | output | 1 | Entry-taken strobe |
| cause_err_o | output | 1 | Unknown-cause strobe |
| mode_o | output | 1 | New mode flag |
| pc_o | output | ADDR_W | Handler entry PC |
| exc_addr_o | output | ADDR_W | Saved return address with mode tag |
| err_code_o | output | 8 | Latched error code |

## Verification
Every result of this unit is due exactly one clock edge after its inputs are presented: the taken and error strobes, the new PC, the saved address, the mode flag and the error code. The bench drives inputs on the falling edge. The reference model computes the expected outputs from those same inputs, and the bench compares at the next falling edge. Held values are checked in every cycle without an entry, so a spurious update shows up in the first cycle it happens.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NUM_IRQ  = 4;
  localparam int IPL_W    = 3;
  localparam int CAUSE_W  = 4;
  localparam int CODE_W   = 8;
  localparam int OFF_W    = 14;
  localparam int LVL_BASE = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET = 4'd0, CS_MCHK = 4'd1, CS_IPI = 4'd2, CS_CLK = 4'd3,
    CS_DEV = 4'd4, CS_MMF = 4'd5, CS_UNAL = 4'd6, CS_OPC = 4'd7,
    CS_ARITH = 4'd8, CS_FPDIS = 4'd9, CS_CALL = 4'd10
  } cause_e;

  // irq line k -> cause (line 3 mchk ... line 0 device)
  function automatic logic [CAUSE_W-1:0] irq_cause(input int unsigned k);
    return CAUSE_W'(NUM_IRQ - k);
  endfunction
endpackage

// File: rtl/exc_irq_select.sv
module exc_irq_select
  import exc_entry_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IRQ-1:0]  irq_i,
  input  logic [IPL_W-1:0]    ipl_i,
  output logic                any_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  logic [NUM_IRQ-1:0] elig;
  logic [NUM_IRQ-1:0] grant;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_elig
    assign elig[k] = irq_i[k] && ({1'b0, ipl_i} < (IPL_W+1)'(LVL_BASE + k));
  end

  always_comb begin
    grant   = '0;
    cause_o = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (elig[k]) begin
        grant   = '0;
        grant[k] = 1'b1;
        cause_o = irq_cause(k);
      end
    end
  end

  assign any_o = |elig;

  assert_single_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any_o == (grant != '0)));
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_entry_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               valid_o,
  output logic [OFF_W-1:0]   off_o
);
  localparam logic [OFF_W-1:0] PRIV_TBL = OFF_W'(14'h1000);
  localparam logic [OFF_W-1:0] USER_TBL = OFF_W'(14'h2000);

  always_comb begin
    valid_o = 1'b1;
    off_o   = '0;
    if (cause_i < CS_CALL) begin
      off_o = OFF_W'({cause_i, 7'b0});
    end else if (cause_i == CS_CALL) begin
      off_o = (code_i[CODE_W-1] ? USER_TBL : PRIV_TBL) + OFF_W'({code_i[CODE_W-2:0], 6'b0});
    end else begin
      valid_o = 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           irq_i,
  input  logic [2:0]           ipl_i,
  input  logic                 exc_req_i,
  input  logic [3:0]           exc_cause_i,
  input  logic [7:0]           exc_code_i,
  input  logic                 mode_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [ADDR_W-1:0]    base_i,
  output logic                 taken_o,
  output logic                 cause_err_o,
  output logic                 mode_o,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [ADDR_W-1:0]    exc_addr_o,
  output logic [7:0]           err_code_o
);
  logic               irq_any;
  logic [CAUSE_W-1:0] irq_cs;
  logic [CAUSE_W-1:0] sel_cause;
  logic [CODE_W-1:0]  sel_code;
  logic               vec_valid;
  logic [OFF_W-1:0]   vec_off;
  logic               take, bad;

  exc_irq_select u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ipl_i(ipl_i),
    .any_o(irq_any), .cause_o(irq_cs)
  );

  // exception wins over interrupts (R10); interrupts carry a zero code (R9)
  assign sel_cause = exc_req_i ? exc_cause_i : irq_cs;
  assign sel_code  = exc_req_i ? exc_code_i : '0;

  exc_vector_calc u_vec (
    .cause_i(sel_cause), .code_i(sel_code), .valid_o(vec_valid), .off_o(vec_off)
  );

  assign bad  = exc_req_i && !vec_valid;
  assign take = exc_req_i ? vec_valid : (!mode_i && irq_any);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o     <= 1'b0;
      cause_err_o <= 1'b0;
      mode_o      <= 1'b0;
      pc_o        <= '0;
      exc_addr_o  <= '0;
      err_code_o  <= '0;
    end else begin
      taken_o     <= take;
      cause_err_o <= bad;
      if (take) begin
        pc_o       <= base_i + ADDR_W'(vec_off);
        exc_addr_o <= pc_i | ADDR_W'(mode_i);
        mode_o     <= 1'b1;
        err_code_o <= sel_code;
      end
    end
  end

  assert_no_irq_in_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !exc_req_i) |=> !taken_o);
  assert_mode_set_on_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> mode_o);
  assert_tag_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (exc_addr_o[0] == ($past(pc_i[0]) | $past(mode_i))));
  assert_irq_code_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && !$past(exc_req_i)) |-> (err_code_o == '0));
  assert_bad_cause_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_err_o |-> (!taken_o && $stable(pc_o) && $stable(exc_addr_o) && $stable(mode_o)));
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int AW = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] irq = '0; logic [2:0] ipl = '0;
  logic req = 1'b0; logic [3:0] cause = '0; logic [7:0] code = '0;
  logic mode = 1'b0; logic [AW-1:0] pc = '0, base = '0;
  logic taken, cerr, mode_q; logic [AW-1:0] pc_q, ea_q; logic [7:0] ec_q;

  int n_vec = 0, n_bad = 0;
  logic e_taken, e_cerr, e_mode; logic [AW-1:0] e_pc, e_ea; logic [7:0] e_ec;

  always #4 clk = ~clk;

  exc_entry_unit #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ipl_i(ipl), .exc_req_i(req),
    .exc_cause_i(cause), .exc_code_i(code), .mode_i(mode), .pc_i(pc), .base_i(base),
    .taken_o(taken), .cause_err_o(cerr), .mode_o(mode_q), .pc_o(pc_q),
    .exc_addr_o(ea_q), .err_code_o(ec_q));

  function automatic logic [13:0] m_off(input logic [3:0] c, input logic [7:0] k);
    if (c <= 4'd9) return 14'(c) * 14'h80;
    if (k >= 8'h80) return 14'h2000 + (14'(k) - 14'h80) * 14'd64;
    return 14'h1000 + 14'(k) * 14'd64;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [AW-1:0] a, input logic [AW-1:0] e);
    n_vec++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  // apply current inputs for one cycle, predict, check at next falling edge (R12)
  task automatic step(input string tag);
    logic [3:0] c; logic [7:0] k; logic tk; int win;
    tk = 1'b0; c = '0; k = '0; e_cerr = 1'b0;
    if (req) begin
      if (cause <= 4'd10) begin tk = 1'b1; c = cause; k = code; end
      else e_cerr = 1'b1;
    end else if (!mode) begin
      win = -1;
      for (int j = 0; j < 4; j++) if (irq[j] && (int'(ipl) < 4 + j)) win = j;
      if (win >= 0) begin tk = 1'b1; c = 4'(4 - win); k = 8'h00; end
    end
    e_taken = tk;
    if (tk) begin
      e_pc = base + AW'(m_off(c, k)); e_ea = pc | AW'(mode); e_mode = 1'b1; e_ec = k;
    end
    @(posedge clk); @(negedge clk);
    cmp(tag, "taken", AW'(taken), AW'(e_taken));
    cmp(tag, "cause_err", AW'(cerr), AW'(e_cerr));
    cmp(tag, "pc", pc_q, e_pc);
    cmp(tag, "exc_addr", ea_q, e_ea);
    cmp(tag, "mode", AW'(mode_q), AW'(e_mode));
    cmp(tag, "err_code", AW'(ec_q), AW'(e_ec));
  endtask

  task automatic idle();
    req = 1'b0; irq = '0;
  endtask

  initial begin
    #(8*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    e_pc = '0; e_ea = '0; e_mode = 1'b0; e_ec = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "pc", pc_q, '0); cmp("R1", "exc_addr", ea_q, '0);
    cmp("R1", "flags", AW'({taken, cerr, mode_q}), '0); cmp("R1", "err_code", AW'(ec_q), '0);
    rst_n = 1'b1;
    base = 64'hFFFF_0000_0000_0000; pc = 64'h0000_0000_1234_5678;
    step("R1");
    // R3: every level with all lines asserted
    for (int l = 0; l < 8; l++) begin
      irq = 4'hF; ipl = 3'(l); step("R3"); idle(); step("R3");
    end
    // R3: single lines at their thresholds
    irq = 4'b0001; ipl = 3'd3; step("R3"); ipl = 3'd4; step("R3");
    irq = 4'b0010; ipl = 3'd4; step("R3"); ipl = 3'd5; step("R3");
    irq = 4'b1000; ipl = 3'd6; step("R3"); ipl = 3'd7; step("R3");
    // R4: priority pairs
    ipl = 3'd0;
    irq = 4'b0011; step("R4"); irq = 4'b0110; step("R4"); irq = 4'b1100; step("R4"); irq = 4'b0101; step("R4");
    // R2: privileged mode blocks interrupts but not exceptions
    mode = 1'b1; irq = 4'hF; step("R2");
    req = 1'b1; cause = 4'd5; code = 8'h3C; pc = 64'h0000_0000_0000_0100; step("R2");
    // R7: tag bit with odd mode already set
    step("R7"); idle(); mode = 1'b0;
    // R5: each fixed cause
    for (int c = 0; c < 10; c++) begin
      req = 1'b1; cause = 4'(c); code = 8'(c * 3); pc = 64'h8000 + 64'(c); step("R5");
    end
    // R6: call-trap boundaries
    cause = 4'd10;
    code = 8'h00; step("R6"); code = 8'h7F; step("R6"); code = 8'h80; step("R6"); code = 8'hFF; step("R6");
    // R10: exception beats interrupts
    irq = 4'hF; ipl = 3'd0; cause = 4'd8; code = 8'h11; step("R10");
    // R9: following interrupt clears code
    req = 1'b0; step("R9");
    // R11: unknown causes hold state
    req = 1'b1; cause = 4'd11; step("R11"); cause = 4'd15; irq = '0; step("R11");
    idle(); step("R8");
    // R12 / random mix
    for (int i = 0; i < 3000; i++) begin
      req   = ($urandom_range(0, 2) == 0);
      cause = 4'($urandom_range(0, 15));
      code  = 8'($urandom);
      irq   = 4'($urandom);
      ipl   = 3'($urandom);
      mode  = ($urandom_range(0, 3) == 0);
      pc    = {$urandom, $urandom};
      base  = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_C000;
      step("R12");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule